// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Per-Entry Page Size

This block is a first-level address translation buffer. Each lookup presents a 48-bit virtual address with the current address-space tag (ASID) and virtual-machine tag (VMID). One cycle later the block returns a hit flag, the 40-bit physical address and an attribute byte. Every entry records its own page size, and that size sets both the bits that take part in the compare and the point where the physical base is joined to the page offset. Entries marked global ignore the ASID. The VMID must always match.

On a miss the block raises a request toward a second-level buffer and stops taking lookups until a fill arrives. Fills can arrive at any time. A fill goes into the lowest-numbered empty slot, or into a round-robin victim when no slot is empty. Entries can be invalidated all at once, by ASID, or by VMID.

Control is a two-state machine. In `ST_SERVE` lookups are accepted. An accepted lookup that misses moves the machine to `ST_AWAIT_FILL`, where the request is held. A fill in `ST_AWAIT_FILL` moves the machine back to `ST_SERVE`. Any other input leaves the state as it is.

Top module: `tlbfa`

## Requirements
- R1: `rs_valid` is high in the cycle after a lookup is accepted (`lk_valid` and `lk_ready` both high at a clock edge) and low in every other cycle.
- R2: An entry hits when it is valid and its base equals the virtual address with the page-offset bits cleared. The offset width comes from the entry's size code: 0 gives 12 bits, 1 gives 14, 2 gives 16, 3 gives 21, 4 gives 29, and codes 5 to 7 give 12. If several entries hit, the lowest-numbered entry supplies the result.
- R3: On a hit, `rs_paddr` holds the entry's physical address above the offset width and the virtual address bits below it. `rs_attr` returns the entry's attribute byte.
- R4: A global entry matches under any ASID. A non-global entry matches only when its ASID equals `lk_asid`.
- R5: An entry matches only when its VMID equals `lk_vmid`.
- R6: On a miss, `rs_hit`, `rs_paddr` and `rs_attr` are zero. From the result cycle onward, `l2_req_valid` stays high with the missed address, ASID and VMID held steady, and `lk_ready` stays low. This lasts until the clock edge that sees `fill_valid`. After that edge the request is low and `lk_ready` is high.
- R7: A fill is written into the lowest-numbered invalid entry when at least one entry is invalid.
- R8: When every entry is valid, a fill replaces the entry named by a victim pointer. The pointer is 0 after reset, advances by one on each such fill, and wraps from the last entry to 0.
- R9: An invalidate with kind 0 clears every entry.
- R10: An invalidate with kind 1 clears non-global entries whose ASID equals `inv_asid`, whatever their VMID. Global entries are left in place.
- R11: An invalidate with kind 2 clears every entry whose VMID equals `inv_vmid`, global ones included. Kind 3 changes nothing.
- R12: After reset the table is empty, `rs_valid` and `l2_req_valid` are low, and `lk_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | High when a lookup can be accepted |
| lk_vaddr | input | 48 | Lookup virtual address |
| lk_asid | input | 16 | Current ASID |
| lk_vmid | input | 16 | Current VMID |
| rs_valid | output | 1 | Result valid, one cycle after acceptance |
| rs_hit | output | 1 | Result hit flag |
| rs_paddr | output | 40 | Translated physical address |
| rs_attr | output | 8 | Attributes of the hitting entry |
| l2_req_valid | output | 1 | Miss request to the second level |
| l2_req_vaddr | output | 48 | Missed virtual address |
| l2_req_asid | output | 16 | ASID of the missed lookup |
| l2_req_vmid | output | 16 | VMID of the missed lookup |
| fill_valid | input | 1 | Write a new translation |
| fill_vaddr | input | 48 | Virtual address of the new page |
| fill_paddr | input | 40 | Physical address of the new page |
| fill_size | input | 3 | Page size code |
| fill_global | input | 1 | Entry matches under any ASID |
| fill_asid | input | 16 | ASID of the new entry |
| fill_vmid | input | 16 | VMID of the new entry |
| fill_attr | input | 8 | Attributes of the new entry |
| inv_valid | input | 1 | Invalidate request |
| inv_kind | input | 2 | 0 all, 1 by ASID, 2 by VMID, 3 none |
| inv_asid | input | 16 | ASID for kind 1 |
| inv_vmid | input | 16 | VMID for kind 2 |

## Verification
Random lookups are drawn in two ways. Most reuse a stored entry's base with a random offset inside its page, which exercises the per-size address splice. The others take an ASID or VMID that differs from the stored one, or an address that belongs to no entry, so the global rule and the VMID rule can be told apart from plain address misses. Directed cases probe the last offset inside a page of each size and the first address past it. Other directed cases fill the whole table so that the victim pointer walks and wraps. The invalidate cases are arranged so that entries of the same ASID, some global and some not, and entries under a second VMID sit side by side. That shows which entries each kind removes.

// File: rtl/tlbfa_pkg.sv
package tlbfa_pkg;
    localparam int VA_W   = 48;
    localparam int PA_W   = 40;
    localparam int ASID_W = 16;
    localparam int VMID_W = 16;
    localparam int ATTR_W = 8;
    localparam int SZ_W   = 3;

    typedef struct packed {
        logic              vld;
        logic              glob;
        logic [SZ_W-1:0]   size;
        logic [ASID_W-1:0] asid;
        logic [VMID_W-1:0] vmid;
        logic [VA_W-1:0]   vbase;
        logic [PA_W-1:0]   pbase;
        logic [ATTR_W-1:0] attr;
    } tlb_ent_t;

    typedef enum logic [1:0] {
        INV_ALL  = 2'd0,
        INV_ASID = 2'd1,
        INV_VMID = 2'd2,
        INV_NONE = 2'd3
    } inv_kind_e;

    typedef enum logic {
        ST_SERVE      = 1'b0,
        ST_AWAIT_FILL = 1'b1
    } ctl_state_e;

    function automatic int unsigned off_bits(input logic [SZ_W-1:0] s);
        case (s)
            3'd1:    return 14;
            3'd2:    return 16;
            3'd3:    return 21;
            3'd4:    return 29;
            default: return 12;
        endcase
    endfunction

    function automatic logic [VA_W-1:0] low_mask(input logic [SZ_W-1:0] s);
        return (VA_W'(1) << off_bits(s)) - VA_W'(1);
    endfunction
endpackage

// File: rtl/tlbfa_match.sv
module tlbfa_match
    import tlbfa_pkg::*;
#(
    parameter int N_ENTRIES = 48
) (
    input  tlb_ent_t            tbl [N_ENTRIES],
    input  logic [VA_W-1:0]     va,
    input  logic [ASID_W-1:0]   asid,
    input  logic [VMID_W-1:0]   vmid,
    output logic [N_ENTRIES-1:0] hit_vec
);
    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
        logic addr_eq, asid_ok, vmid_ok;
        assign addr_eq = ((va & ~low_mask(tbl[i].size)) == tbl[i].vbase);
        assign asid_ok = tbl[i].glob || (tbl[i].asid == asid);
        assign vmid_ok = (tbl[i].vmid == vmid);
        assign hit_vec[i] = tbl[i].vld && addr_eq && asid_ok && vmid_ok;
    end
endmodule

// File: rtl/tlbfa_alloc.sv
module tlbfa_alloc #(
    parameter int N_ENTRIES = 48,
    localparam int IW = $clog2(N_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_ENTRIES-1:0] vld_vec,
    input  logic                 fill_fire,
    output logic [IW-1:0]        slot
);
    logic [IW-1:0] rr_q;
    logic [IW-1:0] free_idx;
    logic          full;

    assign full = &vld_vec;

    always_comb begin
        free_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (!vld_vec[i]) free_idx = IW'(i);
        end
    end

    assign slot = full ? rr_q : free_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q <= '0;
        end else if (fill_fire && full) begin
            rr_q <= (rr_q == IW'(N_ENTRIES - 1)) ? '0 : rr_q + IW'(1);
        end
    end
endmodule

// File: rtl/tlbfa_ctrl.sv
module tlbfa_ctrl
    import tlbfa_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lk_fire,
    input  logic lk_miss,
    input  logic fill_valid,
    output logic lk_ready,
    output logic req_valid
);
    ctl_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_SERVE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d   = state_q;
        lk_ready  = 1'b0;
        req_valid = 1'b0;
        unique case (state_q)
            ST_SERVE: begin
                lk_ready = 1'b1;
                if (lk_fire && lk_miss) state_d = ST_AWAIT_FILL;
            end
            ST_AWAIT_FILL: begin
                req_valid = 1'b1;
                if (fill_valid) state_d = ST_SERVE;
            end
        endcase
    end
endmodule

// File: rtl/tlbfa.sv
module tlbfa
    import tlbfa_pkg::*;
#(
    parameter int N_ENTRIES = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    output logic              lk_ready,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [VMID_W-1:0] lk_vmid,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic [PA_W-1:0]   rs_paddr,
    output logic [ATTR_W-1:0] rs_attr,
    output logic              l2_req_valid,
    output logic [VA_W-1:0]   l2_req_vaddr,
    output logic [ASID_W-1:0] l2_req_asid,
    output logic [VMID_W-1:0] l2_req_vmid,
    input  logic              fill_valid,
    input  logic [VA_W-1:0]   fill_vaddr,
    input  logic [PA_W-1:0]   fill_paddr,
    input  logic [SZ_W-1:0]   fill_size,
    input  logic              fill_global,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic [VMID_W-1:0] fill_vmid,
    input  logic [ATTR_W-1:0] fill_attr,
    input  logic              inv_valid,
    input  logic [1:0]        inv_kind,
    input  logic [ASID_W-1:0] inv_asid,
    input  logic [VMID_W-1:0] inv_vmid
);
    localparam int IW = $clog2(N_ENTRIES);

    tlb_ent_t             tbl [N_ENTRIES];
    logic [N_ENTRIES-1:0] hit_vec;
    logic [N_ENTRIES-1:0] vld_vec;
    logic [IW-1:0]        sel_idx;
    logic [IW-1:0]        fill_slot;
    logic                 any_hit;
    logic                 lk_fire;
    tlb_ent_t             sel;

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_vld
        assign vld_vec[i] = tbl[i].vld;
    end

    tlbfa_match #(.N_ENTRIES(N_ENTRIES)) u_match (
        .tbl     (tbl),
        .va      (lk_vaddr),
        .asid    (lk_asid),
        .vmid    (lk_vmid),
        .hit_vec (hit_vec)
    );

    tlbfa_alloc #(.N_ENTRIES(N_ENTRIES)) u_alloc (
        .clk       (clk),
        .rst_n     (rst_n),
        .vld_vec   (vld_vec),
        .fill_fire (fill_valid),
        .slot      (fill_slot)
    );

    tlbfa_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_fire    (lk_fire),
        .lk_miss    (!any_hit),
        .fill_valid (fill_valid),
        .lk_ready   (lk_ready),
        .req_valid  (l2_req_valid)
    );

    assign lk_fire = lk_valid && lk_ready;
    assign any_hit = |hit_vec;

    // lowest-numbered hitting entry wins
    always_comb begin
        sel_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) sel_idx = IW'(i);
        end
    end
    assign sel = tbl[sel_idx];

    // table: invalidation first, then the fill overrides its own slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENTRIES; i++) tbl[i] <= '0;
        end else begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                if (inv_valid) begin
                    if (inv_kind == INV_ALL)
                        tbl[i].vld <= 1'b0;
                    else if (inv_kind == INV_ASID && !tbl[i].glob && tbl[i].asid == inv_asid)
                        tbl[i].vld <= 1'b0;
                    else if (inv_kind == INV_VMID && tbl[i].vmid == inv_vmid)
                        tbl[i].vld <= 1'b0;
                end
                if (fill_valid && fill_slot == IW'(i)) begin
                    tbl[i].vld   <= 1'b1;
                    tbl[i].glob  <= fill_global;
                    tbl[i].size  <= fill_size;
                    tbl[i].asid  <= fill_asid;
                    tbl[i].vmid  <= fill_vmid;
                    tbl[i].vbase <= fill_vaddr & ~low_mask(fill_size);
                    tbl[i].pbase <= fill_paddr & ~PA_W'(low_mask(fill_size));
                    tbl[i].attr  <= fill_attr;
                end
            end
        end
    end

    // registered result and held miss payload
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_valid     <= 1'b0;
            rs_hit       <= 1'b0;
            rs_paddr     <= '0;
            rs_attr      <= '0;
            l2_req_vaddr <= '0;
            l2_req_asid  <= '0;
            l2_req_vmid  <= '0;
        end else begin
            rs_valid <= lk_fire;
            if (lk_fire) begin
                rs_hit       <= any_hit;
                rs_paddr     <= any_hit ? (sel.pbase | (PA_W'(lk_vaddr) & PA_W'(low_mask(sel.size)))) : '0;
                rs_attr      <= any_hit ? sel.attr : '0;
                l2_req_vaddr <= lk_vaddr;
                l2_req_asid  <= lk_asid;
                l2_req_vmid  <= lk_vmid;
            end
        end
    end
endmodule

// File: rtl/tlbfa_chk.sv
module tlbfa_chk
    import tlbfa_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            lk_valid,
    input logic            lk_ready,
    input logic [VA_W-1:0] lk_vaddr,
    input logic            rs_valid,
    input logic            rs_hit,
    input logic [PA_W-1:0] rs_paddr,
    input logic            l2_req_valid,
    input logic [VA_W-1:0] l2_req_vaddr,
    input logic            fill_valid
);
    p_result_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> rs_valid);

    p_no_spurious_result_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_valid && lk_ready) |=> !rs_valid);

    p_offset_passes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> (!rs_hit || rs_paddr[11:0] == $past(lk_vaddr[11:0])));

    p_miss_raises_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_hit) |-> (l2_req_valid && !lk_ready));

    p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_req_valid && !fill_valid) |=> (l2_req_valid && $stable(l2_req_vaddr)));

    p_fill_releases_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (l2_req_valid && fill_valid) |=> (!l2_req_valid && lk_ready));
endmodule

bind tlbfa tlbfa_chk u_chk (.*);

// File: tb/tlbfa_test.sv
module tlbfa_test;
    import tlbfa_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int N = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_valid = 1'b0;
    logic lk_ready;
    logic [VA_W-1:0] lk_vaddr = '0;
    logic [ASID_W-1:0] lk_asid = '0;
    logic [VMID_W-1:0] lk_vmid = '0;
    logic rs_valid, rs_hit;
    logic [PA_W-1:0] rs_paddr;
    logic [ATTR_W-1:0] rs_attr;
    logic l2_req_valid;
    logic [VA_W-1:0] l2_req_vaddr;
    logic [ASID_W-1:0] l2_req_asid;
    logic [VMID_W-1:0] l2_req_vmid;
    logic fill_valid = 1'b0;
    logic [VA_W-1:0] fill_vaddr = '0;
    logic [PA_W-1:0] fill_paddr = '0;
    logic [SZ_W-1:0] fill_size = '0;
    logic fill_global = 1'b0;
    logic [ASID_W-1:0] fill_asid = '0;
    logic [VMID_W-1:0] fill_vmid = '0;
    logic [ATTR_W-1:0] fill_attr = '0;
    logic inv_valid = 1'b0;
    logic [1:0] inv_kind = '0;
    logic [ASID_W-1:0] inv_asid = '0;
    logic [VMID_W-1:0] inv_vmid = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench model of the table
    bit              m_vld  [N];
    bit              m_glob [N];
    logic [2:0]      m_size [N];
    logic [15:0]     m_asid [N];
    logic [15:0]     m_vmid [N];
    logic [47:0]     m_vbase[N];
    logic [39:0]     m_pbase[N];
    logic [7:0]      m_attr [N];
    int              m_rr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlbfa #(.N_ENTRIES(N)) uut (.*);

    function automatic logic [47:0] tb_mask(input logic [2:0] s);
        int o;
        o = (s == 3'd1) ? 14 : (s == 3'd2) ? 16 : (s == 3'd3) ? 21 : (s == 3'd4) ? 29 : 12;
        return (48'd1 << o) - 48'd1;
    endfunction

    function automatic logic [47:0] rnd48();
        return {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_fill(input logic [47:0] va, input logic [39:0] pa, input logic [2:0] sz,
                           input bit g, input logic [15:0] a, input logic [15:0] v, input logic [7:0] at);
        int slot;
        bit full;
        slot = -1;
        for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) slot = i;
        full = (slot < 0);
        if (full) slot = m_rr;
        fill_valid = 1'b1; fill_vaddr = va; fill_paddr = pa; fill_size = sz;
        fill_global = g; fill_asid = a; fill_vmid = v; fill_attr = at;
        @(posedge clk);
        @(negedge clk);
        fill_valid = 1'b0;
        if (full) m_rr = (m_rr == N - 1) ? 0 : m_rr + 1;
        m_vld[slot] = 1; m_glob[slot] = g; m_size[slot] = sz; m_asid[slot] = a; m_vmid[slot] = v;
        m_vbase[slot] = va & ~tb_mask(sz);
        m_pbase[slot] = pa & ~tb_mask(sz)[39:0];
        m_attr[slot] = at;
    endtask

    task automatic do_inv(input logic [1:0] k, input logic [15:0] a, input logic [15:0] v);
        inv_valid = 1'b1; inv_kind = k; inv_asid = a; inv_vmid = v;
        @(posedge clk);
        @(negedge clk);
        inv_valid = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (k == 2'd0) m_vld[i] = 0;
            else if (k == 2'd1 && !m_glob[i] && m_asid[i] == a) m_vld[i] = 0;
            else if (k == 2'd2 && m_vmid[i] == v) m_vld[i] = 0;
        end
    endtask

    // lookup; a miss is answered with a fill of the missed address
    task automatic do_lookup(input logic [47:0] va, input logic [15:0] a, input logic [15:0] v,
                             input string tag);
        int hi;
        logic [39:0] e_pa;
        logic [7:0] e_at;
        hi = -1;
        for (int i = N - 1; i >= 0; i--)
            if (m_vld[i] && ((va & ~tb_mask(m_size[i])) == m_vbase[i]) &&
                (m_glob[i] || m_asid[i] == a) && m_vmid[i] == v) hi = i;
        e_pa = (hi >= 0) ? (m_pbase[hi] | (va[39:0] & tb_mask(m_size[hi])[39:0])) : 40'd0;
        e_at = (hi >= 0) ? m_attr[hi] : 8'd0;
        chk(lk_ready == 1'b1, {tag, " R6 ready before lookup"}, 64'(lk_ready), 64'd1);
        lk_valid = 1'b1; lk_vaddr = va; lk_asid = a; lk_vmid = v;
        @(posedge clk);
        @(negedge clk);
        lk_valid = 1'b0;
        chk(rs_valid == 1'b1, {tag, " R1 rs_valid"}, 64'(rs_valid), 64'd1);
        chk(rs_hit == (hi >= 0), {tag, " R2 rs_hit"}, 64'(rs_hit), 64'(hi >= 0));
        chk(rs_paddr == e_pa, {tag, " R3 rs_paddr"}, 64'(rs_paddr), 64'(e_pa));
        chk(rs_attr == e_at, {tag, " R3 rs_attr"}, 64'(rs_attr), 64'(e_at));
        if (hi < 0) begin
            chk(l2_req_valid && l2_req_vaddr == va && l2_req_asid == a && l2_req_vmid == v && !lk_ready,
                {tag, " R6 miss request"}, 64'(l2_req_vaddr), 64'(va));
            @(negedge clk);
            chk(l2_req_valid && !rs_valid, {tag, " R6 request held"}, 64'(l2_req_valid), 64'd1);
            do_fill(va, 40'($urandom()) << 12, 3'($urandom() % 5), $urandom() % 2 == 0, a, v, 8'($urandom()));
            chk(!l2_req_valid && lk_ready, {tag, " R6 released"}, 64'(l2_req_valid), 64'd0);
        end else begin
            chk(!l2_req_valid, {tag, " R6 no request on hit"}, 64'(l2_req_valid), 64'd0);
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rs_valid && !l2_req_valid && lk_ready, "R12 reset outputs", 64'({rs_valid, l2_req_valid, lk_ready}), 64'd1);
        do_lookup(48'h0000_1234_5678, 16'd1, 16'd1, "R12 empty table");
        do_inv(2'd0, 0, 0);

        // page boundary per size code, including a code above 4 (R2)
        for (int s = 0; s < 6; s++) begin
            logic [47:0] base;
            base = 48'h0400_0000_0000 + (48'(s) << 32);
            do_fill(base, 40'h12_0000_0000 + (40'(s) << 30), 3'(s), 1'b1, 16'd1, 16'd1, 8'(s + 8'h40));
            do_lookup(base | tb_mask(3'(s)), 16'd9, 16'd1, "R2 last offset in page");
            do_lookup(base + tb_mask(3'(s)) + 48'd1, 16'd9, 16'd1, "R2 first address past page");
        end

        // ASID and VMID rules (R4, R5)
        do_inv(2'd0, 0, 0);
        do_fill(48'h0000_0AB0_0000, 40'h00_5550_0000, 3'd0, 1'b0, 16'd5, 16'd1, 8'h11);
        do_lookup(48'h0000_0AB0_0123, 16'd5, 16'd1, "R4 same ASID hits");
        do_lookup(48'h0000_0AB0_0123, 16'd6, 16'd1, "R4 other ASID misses");
        do_lookup(48'h0000_0AB0_0123, 16'd5, 16'd2, "R5 other VMID misses");

        // placement and round robin (R7, R8)
        do_inv(2'd0, 0, 0);
        for (int i = 0; i < N; i++)
            do_fill(48'h0100_0000_0000 | (48'(i) << 12), 40'h0A_0000_0000 | (40'(i) << 12), 3'd0, 1'b1, 16'd1, 16'd1, 8'(i));
        do_lookup(48'h0100_0000_0000, 16'd1, 16'd1, "R7 slot 0 filled first");
        do_fill(48'h0200_0000_0000, 40'h0B_0000_0000, 3'd0, 1'b1, 16'd1, 16'd1, 8'hEE);
        do_lookup(48'h0100_0000_0000, 16'd1, 16'd1, "R8 victim 0 replaced");
        do_lookup(48'h0100_0000_2000, 16'd1, 16'd1, "R8 entry 2 kept");
        do_inv(2'd0, 0, 0);
        do_lookup(48'h0200_0000_0000, 16'd1, 16'd1, "R9 all cleared");

        // invalidation kinds (R10, R11)
        do_inv(2'd0, 0, 0);
        do_fill(48'h0000_1000_0000, 40'h1000_0000, 3'd0, 1'b0, 16'd3, 16'd1, 8'h01);
        do_fill(48'h0000_2000_0000, 40'h2000_0000, 3'd0, 1'b1, 16'd3, 16'd1, 8'h02);
        do_fill(48'h0000_3000_0000, 40'h3000_0000, 3'd0, 1'b0, 16'd3, 16'd2, 8'h03);
        do_fill(48'h0000_4000_0000, 40'h4000_0000, 3'd0, 1'b1, 16'd4, 16'd2, 8'h04);
        do_inv(2'd3, 16'd3, 16'd1);
        do_lookup(48'h0000_1000_0000, 16'd3, 16'd1, "R11 kind 3 no effect");
        do_inv(2'd1, 16'd3, 16'd0);
        do_lookup(48'h0000_2000_0000, 16'd3, 16'd1, "R10 global kept");
        do_lookup(48'h0000_3000_0000, 16'd3, 16'd2, "R10 other VMID cleared");
        do_inv(2'd2, 16'd0, 16'd2);
        do_lookup(48'h0000_4000_0000, 16'd4, 16'd2, "R11 global cleared by VMID");
        do_lookup(48'h0000_2000_0000, 16'd7, 16'd1, "R11 other VMID kept");

        // constrained random mix
        for (int n = 0; n < 1500; n++) begin
            int op;
            op = $urandom() % 10;
            if (op < 6) begin
                int k;
                k = $urandom() % N;
                if (m_vld[k] && ($urandom() % 4 != 0)) begin
                    logic [15:0] a, v;
                    a = ($urandom() % 5 == 0) ? 16'($urandom() % 4) : m_asid[k];
                    v = ($urandom() % 6 == 0) ? 16'($urandom() % 3) : m_vmid[k];
                    do_lookup(m_vbase[k] | (rnd48() & tb_mask(m_size[k])), a, v, "R2 random lookup");
                end else begin
                    do_lookup(rnd48(), 16'($urandom() % 4), 16'($urandom() % 3), "R2 random address");
                end
            end else if (op < 9) begin
                do_fill((48'($urandom() % 8) << 30) | (rnd48() & 48'h3FFF_FFFF), 40'($urandom()) << 8,
                        3'($urandom() % 6), $urandom() % 3 == 0, 16'($urandom() % 4),
                        16'($urandom() % 3), 8'($urandom()));
            end else begin
                do_inv(2'($urandom() % 4), 16'($urandom() % 4), 16'($urandom() % 3));
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule